// File: doc/BRIEF.md
# Serial Register Slave

This block is the configuration port of a mixed-signal monitor and trim device. A host drives four wires: an active-low select, a serial clock, command data in and reply data out. Each transaction opens with a command byte that names a register, then carries zero, one or two data bytes. The number of data bytes depends on the register. For a converter code register it also depends on the resolution chosen for that converter.

Write data is gathered into holding bytes. The addressed register is updated only once the select returns high, and only if every byte the command needs has arrived. Read commands return the interrupt flag byte or a 10-bit conversion result from inputs supplied by neighbouring logic.

All of the serial pins are sampled in the system clock domain. The serial clock must run at no more than a quarter of the system clock rate. The reply pin is modelled as a data bit plus an output enable, which the pad ring turns into a tri-state driver.

Top module: `serial_reg_slave`

## Requirements
- R1: While reset is asserted, every register output is zero and `reply_oe` is low.
- R2: Bytes move most significant bit first. A `mosi` bit is taken on each rising edge of `sclk` while `ss_n` is low, and the command byte is the first eight bits after `ss_n` falls.
- R3: Command 0x01 carries no data. At the end of its transaction it clears every write register to zero.
- R4: A converter code write (0xD4, 0xD5 or 0xD6 for converters 0, 1 and 2) takes one byte when that converter's resolution bit is 0, and the code becomes {2'b00, byte}. When the bit is 1 it takes two bytes, and the code becomes {second[1:0], first}. The resolution bits are bits 7, 6 and 5 of `dac_ctl` for converters 0, 1 and 2.
- R5: Command 0xD2 takes two bytes: the first goes to `atten_a` and the second to `atten_b`. Commands 0xD8 to 0xDB take two bytes for limit channels 0 to 3: the first byte is the upper limit (`cmp_hi[8i+:8]`) and the second is the lower limit (`cmp_lo[8i+:8]`).
- R6: Commands 0xD0, 0xD3 and 0xD7 each take one byte, which is stored whole in `clk_ctl`, `dac_ctl` and `adc_ctl` respectively.
- R7: A read of 0xDC to 0xDF returns two bytes for result channels 0 to 3, where channel i is `adc_result[10i+:10]`. The first byte is result bits 7..0, and the second is six zeros followed by result bits 9..8. A read of 0xD1 returns `irq_flags` as one byte.
- R8: `reply_oe` is high only while read data bytes are being returned, and is low otherwise. The bit for each rising `sclk` edge is on `reply_d` before that edge arrives, and the bit moves on after the edge.
- R9: Register outputs change only after `ss_n` returns high. They never change in the middle of a transaction.
- R10: If a transaction ends before all the data bytes its command needs have arrived, the register is left unchanged. Bytes sent beyond the ones needed are ignored.
- R11: A command byte outside the register set changes no register. If clocked for data, it returns one zero byte with `reply_oe` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ss_n | input | 1 | Active-low transaction select |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Command and write data, MSB first |
| reply_d | output | 1 | Reply data bit |
| reply_oe | output | 1 | Reply driver enable |
| irq_flags | input | 8 | Flag byte returned by 0xD1 |
| adc_result | input | 40 | Four 10-bit conversion results |
| clk_ctl | output | 8 | Converter clock control byte |
| atten_a | output | 8 | First attenuator setting |
| atten_b | output | 8 | Second attenuator setting |
| dac_ctl | output | 8 | Converter resolution and enable byte |
| adc_ctl | output | 8 | Conversion control byte |
| dac_code | output | 30 | Three 10-bit converter codes |
| cmp_hi | output | 32 | Four upper limit bytes |
| cmp_lo | output | 32 | Four lower limit bytes |

## Verification
The checks assume the host leaves `ss_n` low for at least four system clocks after the last rising `sclk` edge. They also assume the host raises `ss_n` only while `sclk` is low, and that each `sclk` phase lasts at least two system clocks; without these, the synchronised edge could land after the frame has closed. The bench keeps each serial clock phase at four system clocks and pads every frame edge with idle cycles. It also holds `adc_result` and `irq_flags` steady throughout each read frame, so the returned bytes are defined.

// File: rtl/serial_reg_slave.sv
module serial_reg_slave (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ss_n,
  input  logic        sclk,
  input  logic        mosi,
  output logic        reply_d,
  output logic        reply_oe,
  input  logic [7:0]  irq_flags,
  input  logic [39:0] adc_result,
  output logic [7:0]  clk_ctl,
  output logic [7:0]  atten_a,
  output logic [7:0]  atten_b,
  output logic [7:0]  dac_ctl,
  output logic [7:0]  adc_ctl,
  output logic [29:0] dac_code,
  output logic [31:0] cmp_hi,
  output logic [31:0] cmp_lo
);
  localparam logic [7:0] A_CLR  = 8'h01;
  localparam logic [7:0] A_CLK  = 8'hD0;
  localparam logic [7:0] A_FLG  = 8'hD1;
  localparam logic [7:0] A_ATT  = 8'hD2;
  localparam logic [7:0] A_DCTL = 8'hD3;
  localparam logic [7:0] A_DAC0 = 8'hD4;
  localparam logic [7:0] A_ACTL = 8'hD7;
  localparam logic [7:0] A_LIM0 = 8'hD8;
  localparam logic [5:0] A_RES  = 6'b110111;
  localparam int NDAC = 3;
  localparam int NLIM = 4;

  logic [2:0] sck_s, cs_s;
  logic [1:0] mo_s;
  logic [2:0] bitc;
  logic [1:0] nbyt, need;
  logic [6:0] shin;
  logic [7:0] cmd, b1, b2, rsh;

  wire       rise   = sck_s[1] & ~sck_s[2];
  wire       in_frm = ~cs_s[1];
  wire       done   = cs_s[1] & ~cs_s[2];
  wire [7:0] inbyte = {shin, mo_s[1]};

  function automatic logic [1:0] need_of(input logic [7:0] a, input logic [7:0] dc);
    case (a)
      A_CLR:                      return 2'd0;
      A_CLK, A_DCTL, A_ACTL:      return 2'd1;
      A_ATT:                      return 2'd2;
      8'hD8, 8'hD9, 8'hDA, 8'hDB: return 2'd2;
      8'hD4:                      return dc[7] ? 2'd2 : 2'd1;
      8'hD5:                      return dc[6] ? 2'd2 : 2'd1;
      8'hD6:                      return dc[5] ? 2'd2 : 2'd1;
      default:                    return 2'd3;
    endcase
  endfunction

  function automatic logic [7:0] rd_byte(input logic [7:0] a, input logic second);
    if (a == A_FLG && !second) return irq_flags;
    if (a[7:2] == A_RES)
      return second ? {6'b0, adc_result[int'(a[1:0])*10+8 +: 2]}
                    : adc_result[int'(a[1:0])*10 +: 8];
    return 8'h00;
  endfunction

  assign reply_d = reply_oe & rsh[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s <= '0;
      cs_s  <= '1;
      mo_s  <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sclk};
      cs_s  <= {cs_s[1:0], ss_n};
      mo_s  <= {mo_s[0], mosi};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bitc <= '0; nbyt <= '0; need <= 2'd3; shin <= '0;
      cmd <= '0; b1 <= '0; b2 <= '0; rsh <= '0; reply_oe <= 1'b0;
    end else if (!in_frm) begin
      bitc <= '0; nbyt <= done ? nbyt : 2'd0; rsh <= '0; reply_oe <= 1'b0;
    end else if (rise) begin
      shin <= inbyte[6:0];
      bitc <= bitc + 3'd1;
      rsh  <= {rsh[6:0], 1'b0};
      if (bitc == 3'd7) begin
        if (nbyt != 2'd3) nbyt <= nbyt + 2'd1;
        case (nbyt)
          2'd0: begin
            cmd  <= inbyte;
            need <= need_of(inbyte, dac_ctl);
            if (need_of(inbyte, dac_ctl) == 2'd3) begin
              reply_oe <= 1'b1;
              rsh      <= rd_byte(inbyte, 1'b0);
            end
          end
          2'd1: begin
            b1 <= inbyte;
            if (reply_oe && cmd[7:2] == A_RES) rsh <= rd_byte(cmd, 1'b1);
            else reply_oe <= 1'b0;
          end
          2'd2: begin
            b2 <= inbyte;
            reply_oe <= 1'b0;
          end
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_ctl <= '0; atten_a <= '0; atten_b <= '0; dac_ctl <= '0; adc_ctl <= '0;
      dac_code <= '0; cmp_hi <= '0; cmp_lo <= '0;
    end else if (done && nbyt > need) begin
      if (cmd == A_CLR) begin
        clk_ctl <= '0; atten_a <= '0; atten_b <= '0; dac_ctl <= '0; adc_ctl <= '0;
        dac_code <= '0; cmp_hi <= '0; cmp_lo <= '0;
      end
      if (cmd == A_CLK)  clk_ctl <= b1;
      if (cmd == A_DCTL) dac_ctl <= b1;
      if (cmd == A_ACTL) adc_ctl <= b1;
      if (cmd == A_ATT) begin
        atten_a <= b1;
        atten_b <= b2;
      end
      for (int i = 0; i < NDAC; i++)
        if (cmd == A_DAC0 + 8'(i))
          dac_code[10*i +: 10] <= dac_ctl[7-i] ? {b2[1:0], b1} : {2'b00, b1};
      for (int i = 0; i < NLIM; i++)
        if (cmd == A_LIM0 + 8'(i)) begin
          cmp_hi[8*i +: 8] <= b1;
          cmp_lo[8*i +: 8] <= b2;
        end
    end
endmodule

// File: rtl/serial_reg_slave_chk.sv
module serial_reg_slave_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         ss_n,
  input logic         reply_oe,
  input logic [133:0] regs
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (regs == '0 && !reply_oe));

  assert_idle_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n && $past(ss_n) && $past(ss_n, 2) && $past(ss_n, 3)) |-> !reply_oe);

  assert_oe_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reply_oe) |-> (!ss_n && !$past(ss_n)));

  assert_frame_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_n && !$past(ss_n) && !$past(ss_n, 2) && !$past(ss_n, 3) && !$past(ss_n, 4))
      |-> $stable(regs));
endmodule

bind serial_reg_slave serial_reg_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .reply_oe(reply_oe),
  .regs({clk_ctl, atten_a, atten_b, dac_ctl, adc_ctl, dac_code, cmp_hi, cmp_lo})
);

// File: tb/serial_reg_slave_test.sv
module serial_reg_slave_test;
  logic clk = 0, rst_n = 0, ss_n = 1, sclk = 0, mosi = 0;
  logic [7:0] irq_flags = 0;
  logic [39:0] adc_result = 0;
  logic reply_d, reply_oe;
  logic [7:0] clk_ctl, atten_a, atten_b, dac_ctl, adc_ctl;
  logic [29:0] dac_code;
  logic [31:0] cmp_hi, cmp_lo;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [7:0] m_clk, m_atta, m_attb, m_dctl, m_actl;
  logic [29:0] m_dac;
  logic [31:0] m_hi, m_lo;

  always #2 clk = ~clk;

  serial_reg_slave uut (.*);

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  task automatic xbyte(input logic [7:0] b, output logic [7:0] r, output logic [7:0] oe);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      tick(4);
      r[i] = reply_d; oe[i] = reply_oe;
      sclk = 1; tick(4); sclk = 0;
    end
  endtask

  task automatic open_frame(); ss_n = 0; tick(4); endtask
  task automatic close_frame(); tick(4); ss_n = 1; tick(8); endtask

  function automatic int need_m(input logic [7:0] a);
    case (a)
      8'h01: return 0;
      8'hD0, 8'hD3, 8'hD7: return 1;
      8'hD2, 8'hD8, 8'hD9, 8'hDA, 8'hDB: return 2;
      8'hD4: return m_dctl[7] ? 2 : 1;
      8'hD5: return m_dctl[6] ? 2 : 1;
      8'hD6: return m_dctl[5] ? 2 : 1;
      default: return 9;
    endcase
  endfunction

  task automatic model_apply(input logic [7:0] a, input logic [7:0] x, input logic [7:0] y);
    if (a == 8'h01) begin
      m_clk = 0; m_atta = 0; m_attb = 0; m_dctl = 0; m_actl = 0; m_dac = 0; m_hi = 0; m_lo = 0;
    end
    if (a == 8'hD0) m_clk = x;
    if (a == 8'hD3) m_dctl = x;
    if (a == 8'hD7) m_actl = x;
    if (a == 8'hD2) begin m_atta = x; m_attb = y; end
    for (int i = 0; i < 3; i++)
      if (a == 8'hD4 + 8'(i)) m_dac[10*i +: 10] = m_dctl[7-i] ? {y[1:0], x} : {2'b00, x};
    for (int i = 0; i < 4; i++)
      if (a == 8'hD8 + 8'(i)) begin m_hi[8*i +: 8] = x; m_lo[8*i +: 8] = y; end
  endtask

  task automatic check_all(string tag);
    chk({tag, " clk_ctl"}, 64'(clk_ctl), 64'(m_clk));
    chk({tag, " atten_a"}, 64'(atten_a), 64'(m_atta));
    chk({tag, " atten_b"}, 64'(atten_b), 64'(m_attb));
    chk({tag, " dac_ctl"}, 64'(dac_ctl), 64'(m_dctl));
    chk({tag, " adc_ctl"}, 64'(adc_ctl), 64'(m_actl));
    chk({tag, " dac_code"}, 64'(dac_code), 64'(m_dac));
    chk({tag, " cmp_hi"}, 64'(cmp_hi), 64'(m_hi));
    chk({tag, " cmp_lo"}, 64'(cmp_lo), 64'(m_lo));
    chk({tag, " reply_oe idle"}, 64'(reply_oe), 64'(0));
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] x, input logic [7:0] y,
                          input logic [7:0] z, input int nsent, input string tag);
    logic [7:0] r, oe;
    int nd;
    nd = need_m(a);
    open_frame();
    xbyte(a, r, oe);
    if (nsent > 0) xbyte(x, r, oe);
    if (nsent > 1) xbyte(y, r, oe);
    if (nsent > 2) xbyte(z, r, oe);
    close_frame();
    if (nsent >= nd) model_apply(a, x, y);
    check_all(tag);
  endtask

  task automatic do_read(input logic [7:0] a, input int nb, input string tag);
    logic [7:0] r, oe, er;
    int len;
    len = (a[7:2] == 6'b110111) ? 2 : (need_m(a) == 9 ? 1 : 0);
    open_frame();
    xbyte(a, r, oe);
    chk({tag, " R8 oe during command"}, 64'(oe), 64'(0));
    for (int k = 0; k < nb; k++) begin
      xbyte(8'h00, r, oe);
      if (a == 8'hD1) er = irq_flags;
      else if (a[7:2] == 6'b110111)
        er = (k == 0) ? adc_result[int'(a[1:0])*10 +: 8] : {6'b0, adc_result[int'(a[1:0])*10+8 +: 2]};
      else er = 8'h00;
      if (k < len) begin
        chk({tag, " R8 oe during data"}, 64'(oe), 64'hFF);
        chk({tag, " R7/R11 data"}, 64'(r), 64'(er));
      end else
        chk({tag, " R8 oe past last byte"}, 64'(oe), 64'(0));
    end
    close_frame();
    chk({tag, " R8 oe after frame"}, 64'(reply_oe), 64'(0));
  endtask

  initial begin
    logic [7:0] r, oe;
    void'($urandom(32'd839));
    m_clk = 0; m_atta = 0; m_attb = 0; m_dctl = 0; m_actl = 0; m_dac = 0; m_hi = 0; m_lo = 0;
    tick(5);
    check_all("R1 reset");
    rst_n = 1;
    tick(5);

    do_write(8'hD0, 8'h03, 8'h00, 8'h00, 1, "R6 clk byte");
    do_write(8'hD7, 8'h70, 8'h00, 8'h00, 1, "R6 adc ctl");
    do_write(8'hD0, 8'h80, 8'h00, 8'h00, 1, "R2 msb first");
    chk("R2 msb lands in bit7", 64'(clk_ctl), 64'h80);
    do_write(8'hD2, 8'h3F, 8'h21, 8'h00, 2, "R5 attenuators");
    do_write(8'hDA, 8'hC0, 8'h10, 8'h00, 2, "R5 limits ch2");
    do_write(8'hD4, 8'hA5, 8'h00, 8'h00, 1, "R4 8-bit code");
    chk("R4 8-bit value", 64'(dac_code[9:0]), 64'h0A5);
    do_write(8'hD3, 8'h8E, 8'h00, 8'h00, 1, "R6 dac ctl");
    do_write(8'hD4, 8'h34, 8'h03, 8'h00, 2, "R4 10-bit code");
    chk("R4 10-bit value", 64'(dac_code[9:0]), 64'h334);
    do_write(8'hD5, 8'h77, 8'hFF, 8'h00, 2, "R4 8-bit with extra byte");
    chk("R10 extra ignored", 64'(dac_code[19:10]), 64'h077);

    open_frame();
    xbyte(8'hD0, r, oe); xbyte(8'h5A, r, oe);
    tick(12);
    chk("R9 mid-frame unchanged", 64'(clk_ctl), 64'(m_clk));
    close_frame();
    model_apply(8'hD0, 8'h5A, 8'h00);
    check_all("R9 after frame");

    do_write(8'hD2, 8'h11, 8'h22, 8'h00, 1, "R10 short attenuator");
    do_write(8'hD4, 8'h99, 8'h00, 8'h00, 1, "R10 short 10-bit code");
    do_write(8'hD9, 8'h00, 8'h00, 8'h00, 0, "R10 command only");
    do_write(8'h55, 8'hAA, 8'hBB, 8'hCC, 3, "R11 unknown write");

    adc_result = 40'h3_A5C7_1E2B4; irq_flags = 8'h96;
    for (int c = 0; c < 4; c++) do_read(8'hDC + 8'(c), 2, "R7 result read");
    do_read(8'hD1, 2, "R7 flag read");
    do_read(8'h42, 1, "R11 unknown read");

    do_write(8'h01, 8'h00, 8'h00, 8'h00, 0, "R3 clear all");
    chk("R3 all zero", 64'(dac_code), 64'(0));

    for (int it = 0; it < 60; it++) begin
      logic [7:0] a;
      int sel;
      sel = $urandom_range(0, 14);
      case (sel)
        0: a = 8'hD0; 1: a = 8'hD2; 2: a = 8'hD3; 3: a = 8'hD4; 4: a = 8'hD5;
        5: a = 8'hD6; 6: a = 8'hD7; 7: a = 8'hD8; 8: a = 8'hD9; 9: a = 8'hDA;
        10: a = 8'hDB; 11: a = 8'h01; 12: a = 8'hD3; 13: a = 8'hD4;
        default: a = 8'(8'h02 + $urandom_range(0, 8'hC0));
      endcase
      do_write(a, 8'($urandom), 8'($urandom), 8'($urandom), $urandom_range(0, 3), "R4/R5/R6/R10 random");
      if (it % 4 == 0) begin
        adc_result = {8'($urandom), 32'($urandom)};
        irq_flags = 8'($urandom);
        do_read(8'hDC + 8'($urandom_range(0, 3)), 2, "R7 random read");
      end
    end
    finish_run();
  end
endmodule